// File: doc/BRIEF.md
# Timer Compare Unit with Event Trigger

The block pairs a free-running timer with a compare register. The timer advances by one on every clock cycle in which the tick input is high. The block watches continuously for the moment the timer count becomes equal to the compare value, using all bits of both. When that moment arrives, it carries out the action picked by a 4-bit mode field. It can set, clear or toggle a latched pin output. It can raise only an interrupt pulse. Or it can fire a special event trigger, which requests a converter start and restarts the timer.

The trigger is reported at once, but the timer restart waits for the first active tick at or after the match. Rewriting the compare value while the restart is still waiting cancels it. A restart from the trigger never produces the timer wrap pulse. Software reaches the block through a single write port. A select bit picks either the compare register or the mode register, and the mode lives in the low four data bits.

Top module: `cmp_event_unit`

## Requirements
- R1: The compare flag `cmp_flag_o` pulses for one cycle, on the clock edge after the cycle in which `timer_o` first equals the compare value in every bit. It does so in each active mode (0010, 1000, 1001, 1010, 1011).
- R2: In mode 0010, each match inverts `pin_o` on the same edge that raises the compare flag.
- R3: In mode 1000 a match drives `pin_o` to 1. In mode 1001 a match drives it to 0.
- R4: In mode 1010 a match raises only the compare flag. `pin_o` keeps its latched value and `pin_oe_o` stays 0.
- R5: In mode 1011 a match raises the compare flag. It pulses `adc_start_o` on the same edge only if `adc_en_i` was high in the match cycle.
- R6: After a mode 1011 match, the timer holds its value while `tick_i` is low. It becomes 0 on the first edge at or after the match cycle at which `tick_i` is high.
- R7: `tmr_wrap_o` pulses for one cycle when a tick moves the timer from all ones to 0. A timer restart caused by the trigger never raises it.
- R8: A write to the compare register (`wr_sel_i` = 0) in the match cycle, or while the restart is pending, cancels the restart. The timer then keeps counting.
- R9: Writing mode 0000 (`wr_sel_i` = 1, data bits [3:0] = 0) forces `pin_o` to 0 on the next edge.
- R10: `pin_oe_o` is 1 only while the mode is 0010, 1000 or 1001. Codes other than 0010, 1000, 1001, 1010 and 1011 disable the unit, and a match then gives no flag.
- R11: Each equality event acts once. While the timer rests on the compare value, no further flag, pin change or trigger occurs.
- R12: After reset the timer, the compare value and the mode are 0, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timer clock enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the compare register, 1 selects the mode register |
| wr_data_i | input | TMR_W | Write data; the mode uses bits [3:0] |
| adc_en_i | input | 1 | Enables the conversion-start pulse in trigger mode |
| timer_o | output | TMR_W | Current timer count |
| tmr_wrap_o | output | 1 | One-cycle pulse on a natural timer wrap |
| pin_o | output | 1 | Latched compare output level |
| pin_oe_o | output | 1 | Drive enable for the compare output |
| cmp_flag_o | output | 1 | One-cycle compare interrupt pulse |
| adc_start_o | output | 1 | One-cycle conversion-start request |

## Verification
The hardest situation to reach is the window between a trigger and the deferred timer restart. A compare write has to fall inside that window, or the restart has to coincide with the timer at all ones. The bench reaches the window by watching `timer_o`. In the cycle the count reaches the compare value, it drops `tick_i`, which holds the pending restart open for as many cycles as needed before it writes or ticks again. For the wrap case, it lets the timer run a full period up to all ones with the compare value set there.

// File: rtl/cmp_event_pkg.sv
package cmp_event_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF     = 4'b0000,
    MD_TOGGLE  = 4'b0010,
    MD_SET     = 4'b1000,
    MD_CLEAR   = 4'b1001,
    MD_SOFTIRQ = 4'b1010,
    MD_TRIGGER = 4'b1011
  } cmp_mode_e;

  typedef struct packed {
    logic drive;
    logic toggle;
    logic set;
    logic clear;
    logic irq;
    logic trig;
  } act_s;

  function automatic act_s decode_mode(input logic [MODE_W-1:0] m);
    act_s a;
    a = '0;
    case (m)
      MD_TOGGLE:  begin a.drive = 1'b1; a.toggle = 1'b1; a.irq = 1'b1; end
      MD_SET:     begin a.drive = 1'b1; a.set    = 1'b1; a.irq = 1'b1; end
      MD_CLEAR:   begin a.drive = 1'b1; a.clear  = 1'b1; a.irq = 1'b1; end
      MD_SOFTIRQ: begin a.irq = 1'b1; end
      MD_TRIGGER: begin a.irq = 1'b1; a.trig = 1'b1; end
      default:    a = '0;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  output logic [TW-1:0] count_q,
  output logic          wrap_q
);

  localparam logic [TW-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      wrap_q <= tick && !clr && (count_q == CNT_MAX);
      if (tick) begin
        if (clr) count_q <= '0;
        else     count_q <= count_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cmp_detect.sv
module cmp_detect #(
  parameter int TW  = 16,
  parameter int SLW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] count,
  input  logic [TW-1:0] cmp,
  output logic          rise
);

  localparam int NSL = (TW + SLW - 1) / SLW;

  logic [NSL-1:0] sl_eq;
  logic           eq;
  logic           eq_d;

  for (genvar i = 0; i < NSL; i++) begin : g_slice
    localparam int LO = i * SLW;
    localparam int HI = (LO + SLW > TW) ? TW - 1 : LO + SLW - 1;
    assign sl_eq[i] = (count[HI:LO] == cmp[HI:LO]);
  end

  assign eq   = &sl_eq;
  assign rise = eq && !eq_d;

  // eq_d starts high so a power-on equality of zero values is not an event
  always_ff @(posedge clk) begin
    if (rst) eq_d <= 1'b1;
    else     eq_d <= eq;
  end

endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_event_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [TW-1:0]     wr_data,
  output logic [TW-1:0]     cmp_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              drive_q,
  output logic              cmp_wr,
  output logic              mode_clr
);

  logic              mode_wr;
  logic [MODE_W-1:0] new_mode;
  act_s              new_act;

  assign cmp_wr   = wr_en && !wr_sel;
  assign mode_wr  = wr_en && wr_sel;
  assign new_mode = wr_data[MODE_W-1:0];
  assign new_act  = decode_mode(new_mode);
  assign mode_clr = mode_wr && (new_mode == MD_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= '0;
      mode_q  <= MD_OFF;
      drive_q <= 1'b0;
    end else begin
      if (cmp_wr) cmp_q <= wr_data;
      if (mode_wr) begin
        mode_q  <= new_mode;
        drive_q <= new_act.drive;
      end
    end
  end

endmodule

// File: rtl/cmp_action.sv
module cmp_action
  import cmp_event_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic [MODE_W-1:0] mode_q,
  input  logic              mode_clr,
  input  logic              cmp_wr,
  input  logic              tick,
  input  logic              adc_en,
  output logic              pin_q,
  output logic              flag_q,
  output logic              adc_q,
  output logic              tmr_clr
);

  act_s act;
  logic hit;
  logic hit_trig;
  logic pend_q;
  logic pending;

  assign act      = decode_mode(mode_q);
  assign hit      = rise && act.irq;
  assign hit_trig = rise && act.trig;
  assign pending  = (pend_q || hit_trig) && !cmp_wr;
  assign tmr_clr  = tick && pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
      adc_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      flag_q <= hit;
      adc_q  <= hit_trig && adc_en;
      pend_q <= pending && !tick;
      if (mode_clr)                pin_q <= 1'b0;
      else if (hit && act.set)     pin_q <= 1'b1;
      else if (hit && act.clear)   pin_q <= 1'b0;
      else if (hit && act.toggle)  pin_q <= !pin_q;
    end
  end

endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
  import cmp_event_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int CMP_SLICE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [TMR_W-1:0] wr_data_i,
  input  logic             adc_en_i,
  output logic [TMR_W-1:0] timer_o,
  output logic             tmr_wrap_o,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             cmp_flag_o,
  output logic             adc_start_o
);

  logic [TMR_W-1:0]  cmp_q;
  logic [MODE_W-1:0] mode_q;
  logic              cmp_wr;
  logic              mode_clr;
  logic              rise;
  logic              tmr_clr;

  cmp_regs #(.TW(TMR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en_i),
    .wr_sel   (wr_sel_i),
    .wr_data  (wr_data_i),
    .cmp_q    (cmp_q),
    .mode_q   (mode_q),
    .drive_q  (pin_oe_o),
    .cmp_wr   (cmp_wr),
    .mode_clr (mode_clr)
  );

  cmp_timer #(.TW(TMR_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_i),
    .clr     (tmr_clr),
    .count_q (timer_o),
    .wrap_q  (tmr_wrap_o)
  );

  cmp_detect #(.TW(TMR_W), .SLW(CMP_SLICE)) u_detect (
    .clk   (clk),
    .rst   (rst),
    .count (timer_o),
    .cmp   (cmp_q),
    .rise  (rise)
  );

  cmp_action u_action (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise),
    .mode_q   (mode_q),
    .mode_clr (mode_clr),
    .cmp_wr   (cmp_wr),
    .tick     (tick_i),
    .adc_en   (adc_en_i),
    .pin_q    (pin_o),
    .flag_q   (cmp_flag_o),
    .adc_q    (adc_start_o),
    .tmr_clr  (tmr_clr)
  );

endmodule

// File: rtl/cmp_event_chk.sv
module cmp_event_chk #(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic [TMR_W-1:0] wr_data_i,
  input logic             adc_en_i,
  input logic [TMR_W-1:0] timer_o,
  input logic             tmr_wrap_o,
  input logic             pin_o,
  input logic             pin_oe_o,
  input logic             cmp_flag_o,
  input logic             adc_start_o,
  input logic [3:0]       mode_q,
  input logic             tmr_clr
);

  AST_FLAG_ONCE: assert property (@(posedge clk) disable iff (rst)
    cmp_flag_o |=> !cmp_flag_o); // R11

  AST_ADC_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    adc_start_o |-> (cmp_flag_o && $past(adc_en_i))); // R5

  AST_OE_MODES: assert property (@(posedge clk) disable iff (rst)
    pin_oe_o |-> (mode_q == 4'b0010 || mode_q == 4'b1000 || mode_q == 4'b1001)); // R10

  AST_PIN_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (pin_o != $past(pin_o)) |->
      (cmp_flag_o || $past(wr_en_i && wr_sel_i && wr_data_i[3:0] == 4'd0))); // R9

  AST_NO_WRAP_ON_TRIG: assert property (@(posedge clk) disable iff (rst)
    $past(tmr_clr) |-> !tmr_wrap_o); // R7

  AST_CLR_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $past(tmr_clr) |-> ($past(tick_i) && timer_o == '0)); // R6

  AST_WRAP_FROM_MAX: assert property (@(posedge clk) disable iff (rst)
    tmr_wrap_o |-> ($past(tick_i) && $past(timer_o) == '1 && timer_o == '0)); // R7

endmodule

bind cmp_event_unit cmp_event_chk #(.TMR_W(TMR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick_i      (tick_i),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .adc_en_i    (adc_en_i),
  .timer_o     (timer_o),
  .tmr_wrap_o  (tmr_wrap_o),
  .pin_o       (pin_o),
  .pin_oe_o    (pin_oe_o),
  .cmp_flag_o  (cmp_flag_o),
  .adc_start_o (adc_start_o),
  .mode_q      (mode_q),
  .tmr_clr     (tmr_clr)
);

// File: tb/test_cmp_event_unit.sv
`timescale 1ns/1ps
module test_cmp_event_unit;

  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic          wr_sel_i = 1'b0;
  logic [TW-1:0] wr_data_i = '0;
  logic          adc_en_i = 1'b0;
  logic [TW-1:0] timer_o;
  logic          tmr_wrap_o, pin_o, pin_oe_o, cmp_flag_o, adc_start_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cmp_event_unit #(.TMR_W(TW)) i_cmp_event_unit (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .adc_en_i(adc_en_i), .timer_o(timer_o),
    .tmr_wrap_o(tmr_wrap_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .cmp_flag_o(cmp_flag_o), .adc_start_o(adc_start_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic sel, input logic [TW-1:0] d);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  // steps until timer_o shows val; counts flag pulses seen on the way
  task automatic wait_tmr(input logic [TW-1:0] val, output int flags);
    int n = 0;
    flags = 0;
    while (timer_o !== val && n < 70000) begin
      step();
      if (cmp_flag_o) flags++;
      n++;
    end
  endtask

  task automatic arm(input int ahead, output logic [TW-1:0] c);
    c = timer_o + TW'(ahead);
    wr(1'b0, c);
  endtask

  task automatic t_reset();
    chk("R12 timer", 32'(timer_o), 0);
    chk("R12 pin", 32'(pin_o), 0);
    chk("R12 oe", 32'(pin_oe_o), 0);
    chk("R12 flag", 32'(cmp_flag_o), 0);
    chk("R12 adc", 32'(adc_start_o), 0);
    chk("R12 wrap", 32'(tmr_wrap_o), 0);
  endtask

  task automatic t_toggle();
    logic [TW-1:0] c; int f;
    wr(1'b0, 16'd20);
    wr(1'b1, 16'h0002);
    chk("R10 oe toggle", 32'(pin_oe_o), 1);
    tick_i = 1'b1;
    wait_tmr(16'd20, f);
    chk("R1 no early flag", 32'(f), 0);
    step();
    chk("R1 flag", 32'(cmp_flag_o), 1);
    chk("R2 toggle to 1", 32'(pin_o), 1);
    chk("R1 timer", 32'(timer_o), 21);
    step();
    chk("R1 one pulse", 32'(cmp_flag_o), 0);
    arm(5, c);
    wait_tmr(c, f);
    step();
    chk("R2 toggle to 0", 32'(pin_o), 0);
  endtask

  task automatic t_hold();
    logic [TW-1:0] c; int f;
    arm(4, c);
    wait_tmr(c, f);
    tick_i = 1'b0;
    step();
    chk("R11 first flag", 32'(cmp_flag_o), 1);
    chk("R11 toggled", 32'(pin_o), 1);
    f = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      if (cmp_flag_o) f++;
    end
    chk("R11 no retrigger", 32'(f), 0);
    chk("R11 pin held", 32'(pin_o), 1);
    tick_i = 1'b1;
  endtask

  task automatic t_setclr();
    logic [TW-1:0] c; int f;
    wr(1'b1, 16'h0009);
    arm(4, c); wait_tmr(c, f); step();
    chk("R3 clear", 32'(pin_o), 0);
    wr(1'b1, 16'h0008);
    arm(4, c); wait_tmr(c, f); step();
    chk("R3 set", 32'(pin_o), 1);
    arm(4, c); wait_tmr(c, f); step();
    chk("R3 set again flag", 32'(cmp_flag_o), 1);
    chk("R3 set again pin", 32'(pin_o), 1);
  endtask

  task automatic t_zero();
    logic [TW-1:0] c; int f;
    wr(1'b1, 16'h0000);
    chk("R9 pin cleared", 32'(pin_o), 0);
    chk("R10 oe off", 32'(pin_oe_o), 0);
    wr(1'b1, 16'h0005);
    chk("R10 oe undefined", 32'(pin_oe_o), 0);
    arm(4, c); wait_tmr(c, f); step();
    chk("R10 no flag undefined", 32'(cmp_flag_o), 0);
  endtask

  task automatic t_soft();
    logic [TW-1:0] c; int f;
    wr(1'b1, 16'h0008);
    arm(4, c); wait_tmr(c, f); step();
    wr(1'b1, 16'h000A);
    chk("R4 oe", 32'(pin_oe_o), 0);
    chk("R4 pin kept", 32'(pin_o), 1);
    arm(4, c); wait_tmr(c, f); step();
    chk("R4 flag", 32'(cmp_flag_o), 1);
    chk("R4 pin unchanged", 32'(pin_o), 1);
    chk("R4 no adc", 32'(adc_start_o), 0);
  endtask

  task automatic t_trig();
    logic [TW-1:0] c; int f;
    adc_en_i = 1'b1;
    wr(1'b1, 16'h000B);
    chk("R10 oe trig", 32'(pin_oe_o), 0);
    arm(4, c); wait_tmr(c, f);
    tick_i = 1'b0;
    step();
    chk("R5 flag", 32'(cmp_flag_o), 1);
    chk("R5 adc", 32'(adc_start_o), 1);
    chk("R6 held", 32'(timer_o), 32'(c));
    step(); step(); step();
    chk("R6 still held", 32'(timer_o), 32'(c));
    tick_i = 1'b1;
    step();
    chk("R6 reset on tick", 32'(timer_o), 0);
    chk("R7 no wrap", 32'(tmr_wrap_o), 0);
    adc_en_i = 1'b0;
    arm(5, c); wait_tmr(c, f); step();
    chk("R5 flag no adc", 32'(cmp_flag_o), 1);
    chk("R5 adc off", 32'(adc_start_o), 0);
    chk("R6 same tick", 32'(timer_o), 0);
  endtask

  task automatic t_cancel();
    logic [TW-1:0] c; int f;
    adc_en_i = 1'b1;
    arm(4, c); wait_tmr(c, f);
    tick_i = 1'b0;
    step();
    chk("R8 trigger seen", 32'(adc_start_o), 1);
    wr(1'b0, 16'h8000);
    tick_i = 1'b1;
    step();
    chk("R8 cancelled", 32'(timer_o), 32'(c + 1'b1));
  endtask

  task automatic t_wrap();
    int f;
    wr(1'b0, 16'hFFFF);
    wait_tmr(16'hFFFF, f);
    step();
    chk("R7 trig at max to 0", 32'(timer_o), 0);
    chk("R7 trig no wrap", 32'(tmr_wrap_o), 0);
    wr(1'b1, 16'h0000);
    wait_tmr(16'hFFFF, f);
    step();
    chk("R7 natural 0", 32'(timer_o), 0);
    chk("R7 natural wrap", 32'(tmr_wrap_o), 1);
    step();
    chk("R7 wrap pulse", 32'(tmr_wrap_o), 0);
  endtask

  initial begin
    step(); step(); step();
    rst = 1'b0;
    t_reset();
    t_toggle();
    t_hold();
    t_setclr();
    t_zero();
    t_soft();
    t_trig();
    t_cancel();
    t_wrap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule